// File: doc/BRIEF.md
# CAN Controller Interrupt Capture and Rearm Unit

This block sits beside a CAN bus controller. It gathers single-cycle event pulses into an 8-bit interrupt register and drives one interrupt line to the processor. An enable register decides which events may set their pending bit. Software reads the interrupt register through a small register port that has a read strobe. That read clears every pending bit except the receive bit. The receive bit is not stored: it follows the live receive-buffer level.

Two sources use a capture-and-rearm handshake. These are arbitration lost and bus error. The first such event loads its own capture register with an accompanying code: the bit position where arbitration was lost, or the error code. It then locks that source. Further events of the same kind are dropped until software reads that capture register. The read releases the lock, and the next event can raise the interrupt again.

Top module: `can_irq_capture`

## Requirements
- R1: The interrupt register at address 0 reads with receive at bit 0, transmit done at bit 1, error warning at bit 2, error passive at bit 5, arbitration lost at bit 6 and bus error at bit 7. Bits 3 and 4 read as 0. Address 1 is the enable register, address 2 the arbitration-lost capture and address 3 the error-code capture. Captures are zero-extended. Read data is valid combinationally while `bus_rd` is high.
- R2: A read strobe at address 0 clears pending bits 1, 2, 5, 6 and 7 on the following clock edge.
- R3: Bit 0 equals `rx_pending` AND enable bit 0 at all times, and reads do not change it.
- R4: An enabled event that arrives in the same cycle as a clearing read stays pending.
- R5: An event whose enable bit is 0 does not set its pending bit.
- R6: A write to address 1 updates the enable register only while `in_reset_mode` is high. At other times the write is ignored.
- R7: An arbitration-lost event that arrives while its source is unlocked does three things: it loads `arb_pos` into the capture, locks the source, and sets bit 6 if enabled. While locked, further arbitration-lost events change neither the capture nor bit 6. A read of address 2 unlocks the source from the next cycle. An event in the same cycle as that read is dropped.
- R8: Bus-error events follow the same rule as R7, using `berr_code`, bit 7 and address 3.
- R9: `irq_o` is high exactly when some bit of the interrupt register value is set and its enable bit is also set.
- R10: After reset, every pending bit, the enable register, both captures and both locks are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_reset_mode | input | 1 | Controller is in configuration (reset) mode |
| bus_rd | input | 1 | Read strobe, one per read |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| rx_pending | input | 1 | Receive buffer holds at least one frame |
| ev_tx | input | 1 | Transmission finished pulse |
| ev_warn | input | 1 | Error warning change pulse |
| ev_passive | input | 1 | Error passive change pulse |
| ev_arb | input | 1 | Arbitration lost pulse |
| arb_pos | input | ARB_W | Bit position where arbitration was lost |
| ev_berr | input | 1 | Bus error pulse |
| berr_code | input | ECC_W | Error code for the bus error |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench aims at the cycle where an event meets a clearing read. A design that let the clear win would silently lose a transmit or warning interrupt. It repeats status reads while the receive level is high. A design that stored the receive bit, or cleared it on read, would drop an interrupt that still has frames behind it. It fires arbitration-lost and bus-error events while their source is locked, and also in the same cycle as the capture read. A design without the lock would overwrite the first captured code or raise a storm of interrupts. Enable writes outside reset mode are checked to leave the mask unchanged. Long random runs then mix all sources against a reference model.

// File: rtl/can_irq_capture.sv
module can_irq_capture #(
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int ARB_W = 5,
  parameter int ECC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_reset_mode,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             rx_pending,
  input  logic             ev_tx,
  input  logic             ev_warn,
  input  logic             ev_passive,
  input  logic             ev_arb,
  input  logic [ARB_W-1:0] arb_pos,
  input  logic             ev_berr,
  input  logic [ECC_W-1:0] berr_code
  ,output logic            irq_o
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_ARB  = AW'(2);
  localparam logic [AW-1:0] A_ECC  = AW'(3);

  logic [7:0]       en_q;
  logic [7:1]       pend_q;
  logic             arb_lock, ecc_lock;
  logic [ARB_W-1:0] arb_cap;
  logic [ECC_W-1:0] ecc_cap;

  wire rd_stat = bus_rd && (bus_addr == A_STAT);
  wire rd_arb  = bus_rd && (bus_addr == A_ARB);
  wire rd_ecc  = bus_rd && (bus_addr == A_ECC);
  wire wr_en   = bus_wr && (bus_addr == A_EN) && in_reset_mode;

  wire arb_take = ev_arb  && !arb_lock;
  wire ecc_take = ev_berr && !ecc_lock;

  wire [7:1] ev_vec  = {ecc_take, arb_take, ev_passive, 2'b00, ev_warn, ev_tx};
  wire [7:1] set_vec = ev_vec & en_q[7:1];
  wire [7:0] stat    = {pend_q, rx_pending & en_q[0]};

  assign irq_o = |(stat & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      arb_lock <= 1'b0;
      ecc_lock <= 1'b0;
      arb_cap  <= '0;
      ecc_cap  <= '0;
    end else begin
      pend_q   <= set_vec | (rd_stat ? 7'd0 : pend_q);
      arb_lock <= arb_take | (arb_lock & ~rd_arb);
      ecc_lock <= ecc_take | (ecc_lock & ~rd_ecc);
      if (arb_take) arb_cap <= arb_pos;
      if (ecc_take) ecc_cap <= berr_code;
      if (wr_en)    en_q    <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata[7:0]       = stat;
      A_EN:    bus_rdata[7:0]       = en_q;
      A_ARB:   bus_rdata[ARB_W-1:0] = arb_cap;
      A_ECC:   bus_rdata[ECC_W-1:0] = ecc_cap;
      default: bus_rdata            = '0;
    endcase
  end
endmodule

module can_irq_capture_chk #(
  parameter int AW    = 2,
  parameter int ARB_W = 5,
  parameter int ECC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_reset_mode,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic             rx_pending,
  input logic             ev_tx,
  input logic             irq_o,
  input logic [7:0]       en_q,
  input logic [7:1]       pend_q,
  input logic             arb_lock,
  input logic             ecc_lock,
  input logic [ARB_W-1:0] arb_cap,
  input logic [ECC_W-1:0] ecc_cap
);
  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(0) && !ev_tx) |=> !pend_q[1]);
  // R4
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx && en_q[1]) |=> pend_q[1]);
  // R5
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[2] && !pend_q[2]) |=> !pend_q[2]);
  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(1) && in_reset_mode) |=> $stable(en_q));
  // R7
  arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lock && !(bus_rd && bus_addr == AW'(2))) |=> ($stable(arb_cap) && arb_lock));
  // R7
  arb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lock && !pend_q[6]) |=> !pend_q[6]);
  // R8
  ecc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_lock && !(bus_rd && bus_addr == AW'(3))) |=> ($stable(ecc_cap) && ecc_lock));
  // R3
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pending && en_q[0]) |-> irq_o);
  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pending && pend_q == 7'd0) |-> !irq_o);
endmodule

bind can_irq_capture can_irq_capture_chk #(.AW(AW), .ARB_W(ARB_W), .ECC_W(ECC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_reset_mode(in_reset_mode), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .rx_pending(rx_pending), .ev_tx(ev_tx),
  .irq_o(irq_o), .en_q(en_q), .pend_q(pend_q), .arb_lock(arb_lock),
  .ecc_lock(ecc_lock), .arb_cap(arb_cap), .ecc_cap(ecc_cap)
);

// File: tb/test_can_irq_capture.sv
`timescale 1ns/1ps
module test_can_irq_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_reset_mode = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_pending = 1'b0;
  logic       ev_tx = 1'b0, ev_warn = 1'b0, ev_passive = 1'b0;
  logic       ev_arb = 1'b0, ev_berr = 1'b0;
  logic [4:0] arb_pos = '0;
  logic [7:0] berr_code = '0;
  logic       irq_o;

  int tests = 0, fails = 0;

  logic [7:0] mp = '0, men = '0, mecc = '0;
  logic       mal = 1'b0, mel = 1'b0;
  logic [4:0] marb = '0;

  always #2.5 clk = ~clk;

  can_irq_capture i_can_irq_capture (
    .clk(clk), .rst_n(rst_n), .in_reset_mode(in_reset_mode),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_pending(rx_pending), .ev_tx(ev_tx), .ev_warn(ev_warn),
    .ev_passive(ev_passive), .ev_arb(ev_arb), .arb_pos(arb_pos), .ev_berr(ev_berr),
    .berr_code(berr_code), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a, input logic rx);
    case (a)
      2'd0:    return {mp[7:1], rx & men[0]};
      2'd1:    return men;
      2'd2:    return {3'b000, marb};
      default: return mecc;
    endcase
  endfunction

  function automatic logic exp_irq(input logic rx);
    return |({mp[7:1], rx & men[0]} & men);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic [1:0] a, input logic [7:0] wd,
                     input logic tx, input logic wn, input logic ps,
                     input logic ar, input logic [4:0] ap,
                     input logic be, input logic [7:0] bc, input string tag,
                     output logic [7:0] got);
    logic [7:0] ev;
    logic at, bt;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ev_tx = tx; ev_warn = wn; ev_passive = ps;
    ev_arb = ar; arb_pos = ap; ev_berr = be; berr_code = bc;
    #1;
    got = bus_rdata;
    check("R9", {7'd0, irq_o}, {7'd0, exp_irq(rx_pending)});
    if (rd) check(tag, bus_rdata, exp_rd(a, rx_pending));
    @(posedge clk);
    at = ar && !mal;
    bt = be && !mel;
    ev = {bt, at, ps, 2'b00, wn, tx, 1'b0};
    mp = (ev & men) | ((rd && a == 2'd0) ? 8'h00 : mp);
    mal = at | (mal & !(rd && a == 2'd2));
    mel = bt | (mel & !(rd && a == 2'd3));
    if (at) marb = ap;
    if (bt) mecc = bc;
    if (wr && a == 2'd1 && in_reset_mode) men = wd;
    @(negedge clk);
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] g;
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, tag, g);
    check(tag, g, exp);
  endtask

  task automatic idle();
    logic [7:0] g;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9", g);
  endtask

  task automatic wr_en(input logic [7:0] v);
    logic [7:0] g;
    in_reset_mode = 1'b1;
    cyc(0, 1, 2'd1, v, 0, 0, 0, 0, 0, 0, 0, "R6", g);
    in_reset_mode = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", {7'd0, irq_o}, 8'h00);
    rd_exp(2'd0, 8'h00, "R10");
    rd_exp(2'd1, 8'h00, "R10");
    rd_exp(2'd2, 8'h00, "R10");
    rd_exp(2'd3, 8'h00, "R10");
    // R6 write outside reset mode ignored
    cyc(0, 1, 2'd1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, "R6", g);
    rd_exp(2'd1, 8'h00, "R6");
    wr_en(8'hE7);
    rd_exp(2'd1, 8'hE7, "R6");
    // R1 bit layout, R2 clear on read
    cyc(0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R1", g);
    check("R9", {7'd0, irq_o}, 8'h01);
    rd_exp(2'd0, 8'h26, "R1");
    rd_exp(2'd0, 8'h00, "R2");
    check("R2", {7'd0, irq_o}, 8'h00);
    // R3 receive follows level
    rx_pending = 1'b1;
    rd_exp(2'd0, 8'h01, "R3");
    rd_exp(2'd0, 8'h01, "R3");
    check("R3", {7'd0, irq_o}, 8'h01);
    rx_pending = 1'b0;
    #1 check("R3", {7'd0, irq_o}, 8'h00);
    // R4 event on clearing read
    cyc(1, 0, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0, "R4", g);
    rd_exp(2'd0, 8'h02, "R4");
    // R5 masked event
    wr_en(8'h01);
    cyc(0, 0, 0, 0, 1, 1, 1, 1, 5'd7, 1, 8'h11, "R5", g);
    check("R5", {7'd0, irq_o}, 8'h00);
    rd_exp(2'd0, 8'h00, "R5");
    rd_exp(2'd2, 8'h07, "R7");
    rd_exp(2'd3, 8'h11, "R8");
    wr_en(8'hE7);
    // R7 arbitration capture and lock
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd9, 0, 0, "R7", g);
    rd_exp(2'd0, 8'h40, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd20, 0, 0, "R7", g);
    rd_exp(2'd0, 8'h00, "R7");
    cyc(1, 0, 2'd2, 0, 0, 0, 0, 1, 5'd21, 0, 0, "R7", g);
    check("R7", g, 8'h09);
    rd_exp(2'd0, 8'h00, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd3, 0, 0, "R7", g);
    rd_exp(2'd0, 8'h40, "R7");
    rd_exp(2'd2, 8'h03, "R7");
    // R8 bus error capture and lock
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hA5, "R8", g);
    rd_exp(2'd0, 8'h80, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h5A, "R8", g);
    rd_exp(2'd0, 8'h00, "R8");
    rd_exp(2'd3, 8'hA5, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h3C, "R8", g);
    rd_exp(2'd0, 8'h80, "R8");
    rd_exp(2'd3, 8'h3C, "R8");
    idle();
    // random mix, reads tagged by address
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic rd, wr;
      string tg;
      a  = 2'($urandom);
      rd = ($urandom % 3) == 0;
      wr = ($urandom % 20) == 0;
      in_reset_mode = ($urandom % 4) == 0;
      rx_pending = ($urandom % 5) == 0;
      tg = (a == 2'd0) ? "R2" : (a == 2'd1) ? "R6" : (a == 2'd2) ? "R7" : "R8";
      cyc(rd, wr, a, 8'($urandom), ($urandom % 6) == 0, ($urandom % 9) == 0,
          ($urandom % 9) == 0, ($urandom % 7) == 0, 5'($urandom),
          ($urandom % 7) == 0, 8'($urandom), tg, g);
    end
    in_reset_mode = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule